// File: doc/BRIEF.md
# Momentum Lookup Address Builder

This block turns track candidates into read addresses for an external memory that returns a signed transverse momentum. Each of nine candidates carries an azimuth value for up to three stations, a polar coordinate, a track-type code and a flag saying whether a third segment exists. The address logic runs for all nine candidates at once. Three output slots then pick their winners by index and forward the finished addresses, so the memory can be read as soon as the selection is known.

For each candidate, the block subtracts the first station azimuth from the second. It also subtracts the second from the third when a third segment is present. Each difference is reduced to a sign-magnitude code of its own width: the second is coarser, because it only needs to resolve low-momentum scattering. The two codes are packed with the polar and type bits into one 24-bit address.

The input side is a valid/ready stream. One beat carries all candidates and the three slot selections. The output side is a valid/ready stream with one register stage. A beat is taken when `in_valid && in_ready`, and `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds every bit and input is refused.

Top module: `mtl_addr_builder`

## Requirements
- R1: While reset is asserted and after its release with no input, `out_valid` is 0 and `in_ready` is 1.
- R2: The field dphi12 sits at address bits [14:6], with bit 14 as the sign and bits [13:6] as the magnitude. It encodes phi2 − phi1 of the selected candidate, where a positive difference has sign 0 and a negative one has sign 1. The polar coordinate is placed at bits [19:15] and the type at bits [23:20].
- R3: When the magnitude of phi2 − phi1 exceeds 255, the dphi12 magnitude is 255 and the sign is kept. A difference of exactly ±255 passes through unchanged.
- R4: The field dphi23 sits at bits [5:0], with bit 5 as the sign and bits [4:0] as the magnitude. The magnitude is |phi3 − phi2| shifted right by 2 and clamped to 31. The sign bit is 1 only for a negative difference whose shifted magnitude is nonzero.
- R5: For a candidate without a third segment, bits [5:0] are zero whatever phi3 holds.
- R6: A candidate without a third segment is accepted only when its type lies in 8..15 (type bit 3 set). Otherwise its slot is reported invalid with address 0.
- R7: A slot whose select-valid bit is 0, or whose index is 9 or more, reports slot-valid 0 and address 0.
- R8: A beat accepted at a clock edge appears on `out_valid`, `out_slot_vld` and `out_addr` after that edge. Slot s carries the address of the candidate that `sel_idx[4s+3:4s]` names.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and all outputs hold their values.
- R10: When the output is drained and no beat arrives, `out_valid` goes to 0 at the next edge. When a new beat arrives in the same cycle as a drain, the new beat replaces the old one with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high |
| cand_phi1 | input | 108 | Station-1 azimuth, 12 bits per candidate, candidate k at [12k+11:12k] |
| cand_phi2 | input | 108 | Station-2 azimuth, same packing |
| cand_phi3 | input | 108 | Station-3 azimuth, same packing |
| cand_eta | input | 45 | Polar coordinate, 5 bits per candidate |
| cand_type | input | 36 | Track type, 4 bits per candidate |
| cand_has3 | input | 9 | Third segment present, one bit per candidate |
| sel_idx | input | 12 | Candidate index, 4 bits per slot |
| sel_vld | input | 3 | Slot selection valid |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_addr | output | 72 | Memory address, 24 bits per slot |
| out_slot_vld | output | 3 | Slot carries a usable address |

## Verification
The assertions check the handshake on every cycle. A stalled output must stay frozen and keep the input refused, and an accepted beat must produce a valid output on the next cycle. The assertions also check that an invalid slot always shows a zero address. The arithmetic can only be shown by the bench's scenarios. That covers the signed differences, the clamp at 255 and at 31, the shift and the sign cleared on a zero magnitude, and the zeroed second field for two-segment tracks. The same holds for the type gating of two-segment tracks and for the choice of the right candidate per slot.

// File: rtl/mtl_pkg.sv
package mtl_pkg;
  localparam int N_CAND_D    = 9;
  localparam int N_SLOT_D    = 3;
  localparam int PHI_W_D     = 12;
  localparam int ETA_W_D     = 5;
  localparam int TYPE_W_D    = 4;
  localparam int D12_MAG_D   = 8;
  localparam int D23_MAG_D   = 5;
  localparam int D23_SHIFT_D = 2;

  function automatic int addr_width(int type_w, int eta_w, int m12, int m23);
    return type_w + eta_w + (m12 + 1) + (m23 + 1);
  endfunction
endpackage

// File: rtl/mtl_sat_diff.sv
module mtl_sat_diff #(
  parameter int IN_W  = 12,
  parameter int MAG_W = 8,
  parameter int SHIFT = 0
) (
  input  logic [IN_W-1:0]  a,
  input  logic [IN_W-1:0]  b,
  output logic [MAG_W:0]   code
);
  localparam int DW = IN_W + 1;
  localparam logic [IN_W-1:0] MAG_MAX = IN_W'((1 << MAG_W) - 1);

  logic signed [DW-1:0] diff;
  logic signed [DW-1:0] ndiff;
  logic                 neg;
  logic [IN_W-1:0]      mag_full;
  logic [IN_W-1:0]      mag_sh;
  logic [MAG_W-1:0]     mag_sat;

  always_comb begin
    diff     = $signed({1'b0, b}) - $signed({1'b0, a});
    ndiff    = -diff;
    neg      = diff[DW-1];
    mag_full = neg ? ndiff[IN_W-1:0] : diff[IN_W-1:0];
    mag_sh   = mag_full >> SHIFT;
    if (mag_sh > MAG_MAX) mag_sat = MAG_MAX[MAG_W-1:0];
    else                  mag_sat = mag_sh[MAG_W-1:0];
    code = {neg && (mag_sat != '0), mag_sat};
  end
endmodule

// File: rtl/mtl_addr_calc.sv
module mtl_addr_calc #(
  parameter int PHI_W     = 12,
  parameter int ETA_W     = 5,
  parameter int TYPE_W    = 4,
  parameter int D12_MAG   = 8,
  parameter int D23_MAG   = 5,
  parameter int D23_SHIFT = 2,
  parameter logic [(1<<TYPE_W)-1:0] TWO_SEG_OK = '1,
  localparam int ADDR_W = mtl_pkg::addr_width(TYPE_W, ETA_W, D12_MAG, D23_MAG)
) (
  input  logic [PHI_W-1:0]  phi1,
  input  logic [PHI_W-1:0]  phi2,
  input  logic [PHI_W-1:0]  phi3,
  input  logic [ETA_W-1:0]  eta,
  input  logic [TYPE_W-1:0] trk_type,
  input  logic              has3,
  output logic [ADDR_W-1:0] addr,
  output logic              ok
);
  logic [D12_MAG:0] code12;
  logic [D23_MAG:0] code23;
  logic [D23_MAG:0] code23_g;

  mtl_sat_diff #(.IN_W(PHI_W), .MAG_W(D12_MAG), .SHIFT(0)) u_d12 (
    .a(phi1), .b(phi2), .code(code12)
  );

  mtl_sat_diff #(.IN_W(PHI_W), .MAG_W(D23_MAG), .SHIFT(D23_SHIFT)) u_d23 (
    .a(phi2), .b(phi3), .code(code23)
  );

  always_comb begin
    code23_g = has3 ? code23 : '0;
    ok       = has3 || TWO_SEG_OK[trk_type];
    addr     = {trk_type, eta, code12, code23_g};
  end
endmodule

// File: rtl/mtl_slot_pick.sv
module mtl_slot_pick #(
  parameter int N_CAND = 9,
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 4
) (
  input  logic [N_CAND*ADDR_W-1:0] all_addr,
  input  logic [N_CAND-1:0]        all_ok,
  input  logic [IDX_W-1:0]         idx,
  input  logic                     vld,
  output logic [ADDR_W-1:0]        addr,
  output logic                     slot_ok
);
  always_comb begin
    addr    = '0;
    slot_ok = 1'b0;
    for (int k = 0; k < N_CAND; k++) begin
      if (vld && (idx == IDX_W'(k)) && all_ok[k]) begin
        addr    = all_addr[k*ADDR_W +: ADDR_W];
        slot_ok = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mtl_addr_builder.sv
module mtl_addr_builder #(
  parameter int N_CAND    = mtl_pkg::N_CAND_D,
  parameter int N_SLOT    = mtl_pkg::N_SLOT_D,
  parameter int PHI_W     = mtl_pkg::PHI_W_D,
  parameter int ETA_W     = mtl_pkg::ETA_W_D,
  parameter int TYPE_W    = mtl_pkg::TYPE_W_D,
  parameter int D12_MAG   = mtl_pkg::D12_MAG_D,
  parameter int D23_MAG   = mtl_pkg::D23_MAG_D,
  parameter int D23_SHIFT = mtl_pkg::D23_SHIFT_D,
  parameter logic [(1<<TYPE_W)-1:0] TWO_SEG_OK = 16'hFF00,
  localparam int IDX_W  = $clog2(N_CAND),
  localparam int ADDR_W = mtl_pkg::addr_width(TYPE_W, ETA_W, D12_MAG, D23_MAG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [N_CAND*PHI_W-1:0]   cand_phi1,
  input  logic [N_CAND*PHI_W-1:0]   cand_phi2,
  input  logic [N_CAND*PHI_W-1:0]   cand_phi3,
  input  logic [N_CAND*ETA_W-1:0]   cand_eta,
  input  logic [N_CAND*TYPE_W-1:0]  cand_type,
  input  logic [N_CAND-1:0]         cand_has3,
  input  logic [N_SLOT*IDX_W-1:0]   sel_idx,
  input  logic [N_SLOT-1:0]         sel_vld,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [N_SLOT*ADDR_W-1:0]  out_addr,
  output logic [N_SLOT-1:0]         out_slot_vld
);
  logic [N_CAND*ADDR_W-1:0] cand_addr;
  logic [N_CAND-1:0]        cand_ok;
  logic [N_SLOT*ADDR_W-1:0] pick_addr;
  logic [N_SLOT-1:0]        pick_ok;
  logic                     take;

  for (genvar k = 0; k < N_CAND; k++) begin : g_cand
    mtl_addr_calc #(
      .PHI_W(PHI_W), .ETA_W(ETA_W), .TYPE_W(TYPE_W),
      .D12_MAG(D12_MAG), .D23_MAG(D23_MAG), .D23_SHIFT(D23_SHIFT),
      .TWO_SEG_OK(TWO_SEG_OK)
    ) u_calc (
      .phi1     (cand_phi1[k*PHI_W +: PHI_W]),
      .phi2     (cand_phi2[k*PHI_W +: PHI_W]),
      .phi3     (cand_phi3[k*PHI_W +: PHI_W]),
      .eta      (cand_eta[k*ETA_W +: ETA_W]),
      .trk_type (cand_type[k*TYPE_W +: TYPE_W]),
      .has3     (cand_has3[k]),
      .addr     (cand_addr[k*ADDR_W +: ADDR_W]),
      .ok       (cand_ok[k])
    );
  end

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    mtl_slot_pick #(.N_CAND(N_CAND), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_pick (
      .all_addr (cand_addr),
      .all_ok   (cand_ok),
      .idx      (sel_idx[s*IDX_W +: IDX_W]),
      .vld      (sel_vld[s]),
      .addr     (pick_addr[s*ADDR_W +: ADDR_W]),
      .slot_ok  (pick_ok[s])
    );
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_slot_vld <= '0;
    end else if (take) begin
      out_valid    <= 1'b1;
      out_addr     <= pick_addr;
      out_slot_vld <= pick_ok;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/mtl_addr_builder_chk.sv
module mtl_addr_builder_chk #(
  parameter int N_SLOT = 3,
  parameter int ADDR_W = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [N_SLOT*ADDR_W-1:0] out_addr,
  input logic [N_SLOT-1:0]        out_slot_vld
);
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_slot_vld)));

  assert_stall_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_accept_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_drain_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  for (genvar s = 0; s < N_SLOT; s++) begin : g_zero
    assert_dead_slot_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_slot_vld[s]) |-> (out_addr[s*ADDR_W +: ADDR_W] == '0));
  end
endmodule

bind mtl_addr_builder mtl_addr_builder_chk #(.N_SLOT(N_SLOT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_slot_vld(out_slot_vld)
);

// File: tb/mtl_addr_builder_tb.sv
module mtl_addr_builder_tb;
  localparam int NC = 9, NS = 3, PW = 12, EW = 5, TW = 4, IW = 4, AW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [NC*PW-1:0] cand_phi1 = '0, cand_phi2 = '0, cand_phi3 = '0;
  logic [NC*EW-1:0] cand_eta = '0;
  logic [NC*TW-1:0] cand_type = '0;
  logic [NC-1:0]    cand_has3 = '0;
  logic [NS*IW-1:0] sel_idx = '0;
  logic [NS-1:0]    sel_vld = '0;
  logic [NS*AW-1:0] out_addr;
  logic [NS-1:0]    out_slot_vld;

  int n_chk = 0, n_bad = 0;
  int p1[NC], p2[NC], p3[NC], eta[NC], typ[NC];
  bit h3[NC];
  int sidx[NS];
  bit svld[NS];

  always #5 clk = ~clk;

  mtl_addr_builder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .cand_phi1(cand_phi1), .cand_phi2(cand_phi2), .cand_phi3(cand_phi3),
    .cand_eta(cand_eta), .cand_type(cand_type), .cand_has3(cand_has3),
    .sel_idx(sel_idx), .sel_vld(sel_vld), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_slot_vld(out_slot_vld)
  );

  task automatic check(string tag, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int sm(int d, int shift, int magw);
    int m = (d < 0) ? -d : d;
    int mx = (1 << magw) - 1;
    m = m >> shift;
    if (m > mx) m = mx;
    return (((d < 0) && (m != 0)) ? (1 << magw) : 0) | m;
  endfunction

  function automatic int exp_addr(int s);
    int k = sidx[s];
    int d23;
    if (!svld[s] || k >= NC) return 0;
    if (!h3[k] && typ[k] < 8) return 0;
    d23 = h3[k] ? sm(p3[k] - p2[k], 2, 5) : 0;
    return (typ[k] << 20) | (eta[k] << 15) | (sm(p2[k] - p1[k], 0, 8) << 6) | d23;
  endfunction

  function automatic bit exp_ok(int s);
    int k = sidx[s];
    if (!svld[s] || k >= NC) return 0;
    return h3[k] || typ[k] >= 8;
  endfunction

  task automatic pack();
    for (int k = 0; k < NC; k++) begin
      cand_phi1[k*PW +: PW] = PW'(p1[k]);
      cand_phi2[k*PW +: PW] = PW'(p2[k]);
      cand_phi3[k*PW +: PW] = PW'(p3[k]);
      cand_eta[k*EW +: EW]  = EW'(eta[k]);
      cand_type[k*TW +: TW] = TW'(typ[k]);
      cand_has3[k]          = h3[k];
    end
    for (int s = 0; s < NS; s++) begin
      sel_idx[s*IW +: IW] = IW'(sidx[s]);
      sel_vld[s]          = svld[s];
    end
  endtask

  task automatic check_slots(string tag);
    for (int s = 0; s < NS; s++) begin
      check({tag, " slot valid"}, out_slot_vld[s], exp_ok(s));
      check({tag, " slot addr"}, out_addr[s*AW +: AW], exp_addr(s));
    end
  endtask

  task automatic send_and_check(string tag);
    @(negedge clk);
    pack();
    in_valid  = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R8 out_valid"}, out_valid, 1);
    check_slots(tag);
  endtask

  task automatic default_cands();
    for (int k = 0; k < NC; k++) begin
      p1[k] = 100 + 10 * k; p2[k] = p1[k] + 7 * k - 20; p3[k] = p2[k] + 9 * k - 30;
      eta[k] = k + 3; typ[k] = k + 1; h3[k] = 1'b1;
    end
    for (int s = 0; s < NS; s++) svld[s] = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 out_valid in reset", out_valid, 0);
    check("R1 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", out_valid, 0);
  endtask

  task automatic t_basic();
    default_cands();
    sidx[0] = 2; sidx[1] = 5; sidx[2] = 8;
    send_and_check("R2 R8 basic");
    sidx[0] = 8; sidx[1] = 0; sidx[2] = 0;
    send_and_check("R8 reorder");
    @(negedge clk);
    check("R10 drain empties", out_valid, 0);
  endtask

  task automatic t_clamp();
    default_cands();
    p1[0] = 0;    p2[0] = 4095; p3[0] = 4092;
    p1[1] = 4095; p2[1] = 0;    p3[1] = 127;
    p1[2] = 1000; p2[2] = 745;  p3[2] = 873;
    p1[3] = 300;  p2[3] = 556;  p3[3] = 400;
    sidx[0] = 0; sidx[1] = 1; sidx[2] = 2;
    send_and_check("R3 R4 clamp a");
    sidx[0] = 3;
    send_and_check("R3 R4 clamp b");
  endtask

  task automatic t_two_seg();
    default_cands();
    h3[3] = 0; typ[3] = 9; p3[3] = 4000;
    h3[4] = 0; typ[4] = 2;
    h3[5] = 1; typ[5] = 2;
    sidx[0] = 3; sidx[1] = 4; sidx[2] = 5;
    send_and_check("R5 R6 two segment");
  endtask

  task automatic t_dead_slots();
    default_cands();
    sidx[0] = 9; sidx[1] = 1; sidx[2] = 7;
    svld[1] = 1'b0;
    send_and_check("R7 dead slots");
    sidx[0] = 15; sidx[1] = 4; sidx[2] = 4;
    svld[1] = 1'b1;
    send_and_check("R7 R8 index 15 and shared");
  endtask

  task automatic t_backpressure();
    logic [NS*AW-1:0] held_a;
    logic [NS-1:0]    held_v;
    default_cands();
    sidx[0] = 1; sidx[1] = 2; sidx[2] = 3;
    @(negedge clk);
    pack();
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check("R8 stalled beat valid", out_valid, 1);
    check_slots("R8 stalled beat");
    held_a = out_addr; held_v = out_slot_vld;
    sidx[0] = 6; sidx[1] = 7; sidx[2] = 0;
    pack();
    for (int i = 0; i < 3; i++) begin
      check("R9 in_ready low in stall", in_ready, 0);
      @(negedge clk);
      check("R9 addr held", out_addr, held_a);
      check("R9 slot valid held", out_slot_vld, held_v);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 back to back valid", out_valid, 1);
    check_slots("R10 back to back");
    @(negedge clk);
    check("R10 drain empties", out_valid, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_basic();
        t_clamp();
        t_two_seg();
        t_dead_slots();
        t_backpressure();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule